// File: doc/BRIEF.md
# Prioritized Interrupt Flag Controller

This block turns a small set of single-cycle match pulses into sticky interrupt flags and merges them into one interrupt line. Each source has an enable bit. Software sets enables through one register and clears them through another, using write-one semantics in both cases. Software clears flags by writing ones to the flag register.

A read-only offset register reports the number of the most urgent pending source. Source 1 is the most urgent. Reading the offset register also acknowledges that source: its flag is cleared, so the next read reports the next pending source. While the emulation input is high, offset reads return the same value but leave all state untouched. This lets a debugger look at the block without disturbing it.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all flags and all enables are 0. The interrupt output is low and every register reads 0.
- R2: A high bit on `matchIn` in a cycle sets the matching flag at the next clock edge. The flag stays set until software clears it.
- R3: Writing the enable-set register (address 0) sets each enable bit whose data bit is 1. Bits written as 0 keep their value. A read of address 0 or address 1 returns the current enable mask.
- R4: Writing the enable-clear register (address 1) clears each enable bit whose data bit is 1. Bits written as 0 keep their value.
- R5: `irqOut` is high exactly when at least one source has both its flag and its enable set.
- R6: A write to the flag register (address 2) clears each flag whose data bit is 1. Bits written as 0 keep their value. A read of address 2 returns the flags, with source n in bit n-1.
- R7: A read of the offset register (address 3) returns n for the lowest-numbered source n whose flag is set, whatever its enable. It returns 0 when no flag is set.
- R8: A read of the offset register outside emulation clears only the flag of the source it reports.
- R9: Writes to the offset register change no state.
- R10: While `emuMode` is high, offset reads change neither the flags nor the offset value.
- R11: If a match pulse and a clear hit the same flag in the same cycle, the flag ends up set. This holds for a flag-register write and for an offset-read acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| matchIn | input | NUM_SRC | Match pulses; bit n-1 belongs to source n |
| emuMode | input | 1 | Emulation mode; offset reads have no side effect |
| addr | input | ADDR_W | Register address |
| wrEn | input | 1 | Write strobe |
| wrData | input | NUM_SRC | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | NUM_SRC | Read data, valid in the same cycle as `rdEn` |
| irqOut | output | 1 | Combined interrupt |

## Verification
The new-match set path can meet either of the two clear paths in a single cycle. One is a one-to-clear write to the flag register. The other is the acknowledge caused by an offset read. The bench provokes both collisions by driving `matchIn` on the same clock edge as the flag write or the offset read, always on the source being cleared. It judges the outcome by reading the flag register afterwards, expecting the bit still set. A second pairing is an offset read made in emulation mode: it is judged by repeating the read and confirming that the reported index and the flags are unchanged.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int ADR_ENSET  = 0;
  localparam int ADR_ENCLR  = 1;
  localparam int ADR_FLAG   = 2;
  localparam int ADR_OFFSET = 3;

  typedef struct packed {
    logic enSetWr;
    logic enClrWr;
    logic flagWr;
    logic offAck;
  } strobe_t;
endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 3,
  localparam int OFF_W = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] matchIn,
  input  strobe_t            strb,
  input  logic [NUM_SRC-1:0] wrData,
  output logic [NUM_SRC-1:0] flagQ,
  output logic [NUM_SRC-1:0] enQ,
  output logic [OFF_W-1:0]   offIdx,
  output logic               irqOut
);
  logic [NUM_SRC-1:0] topOneHot;
  logic [NUM_SRC-1:0] clrMask;

  // priority pick: lowest bit index wins, reported as index+1
  always_comb begin
    offIdx    = '0;
    topOneHot = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (flagQ[i]) begin
        offIdx    = OFF_W'(i + 1);
        topOneHot = '0;
        topOneHot[i] = 1'b1;
      end
    end
  end

  always_comb begin
    clrMask = '0;
    if (strb.flagWr) clrMask = clrMask | wrData;
    if (strb.offAck) clrMask = clrMask | topOneHot;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= '0;
      enQ   <= '0;
    end else begin
      flagQ <= (flagQ & ~clrMask) | matchIn;
      if (strb.enSetWr)      enQ <= enQ | wrData;
      else if (strb.enClrWr) enQ <= enQ & ~wrData;
    end
  end

  assign irqOut = |(flagQ & enQ);

  a_r2_match_sets: assert property (@(posedge clk) disable iff (!rstN)
    (matchIn != '0) |=> ((flagQ & $past(matchIn)) == $past(matchIn)));

  a_r4_enable_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strb.enClrWr |=> ((enQ & $past(wrData)) == '0));

  a_r8_single_ack: assert property (@(posedge clk) disable iff (!rstN)
    (strb.offAck && !strb.flagWr && matchIn == '0 && flagQ != '0)
      |=> ($countones(flagQ) == $countones($past(flagQ)) - 1));

  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.flagWr || strb.offAck) && matchIn != '0)
      |=> ((flagQ & $past(matchIn)) == $past(matchIn)));
endmodule

// File: rtl/prio_irq_ctl.sv
module prio_irq_ctl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int ADDR_W  = 2,
  localparam int OFF_W = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               emuMode,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [NUM_SRC-1:0] flagQ,
  input  logic [NUM_SRC-1:0] enQ,
  input  logic [OFF_W-1:0]   offIdx,
  output strobe_t            strb,
  output logic [NUM_SRC-1:0] rdData
);
  logic selEnSet, selEnClr, selFlag, selOff;

  assign selEnSet = (addr == ADDR_W'(ADR_ENSET));
  assign selEnClr = (addr == ADDR_W'(ADR_ENCLR));
  assign selFlag  = (addr == ADDR_W'(ADR_FLAG));
  assign selOff   = (addr == ADDR_W'(ADR_OFFSET));

  always_comb begin
    strb.enSetWr = wrEn && selEnSet;
    strb.enClrWr = wrEn && selEnClr;
    strb.flagWr  = wrEn && selFlag;
    strb.offAck  = rdEn && selOff && !emuMode;
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if (selEnSet || selEnClr) rdData = enQ;
      else if (selFlag)         rdData = flagQ;
      else if (selOff)          rdData = NUM_SRC'(offIdx);
    end
  end

  a_r9_offset_write_inert: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && selOff) |-> (!strb.enSetWr && !strb.enClrWr && !strb.flagWr));

  a_r7_idle_offset_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && selOff && flagQ == '0) |-> (rdData == '0));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int ADDR_W  = 2,
  localparam int OFF_W = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] matchIn,
  input  logic               emuMode,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wrEn,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic               rdEn,
  output logic [NUM_SRC-1:0] rdData,
  output logic               irqOut
);
  strobe_t            strb;
  logic [NUM_SRC-1:0] flagQ;
  logic [NUM_SRC-1:0] enQ;
  logic [OFF_W-1:0]   offIdx;

  prio_irq_ctl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .emuMode(emuMode), .addr(addr),
    .wrEn(wrEn), .rdEn(rdEn), .flagQ(flagQ), .enQ(enQ),
    .offIdx(offIdx), .strb(strb), .rdData(rdData)
  );

  prio_irq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rstN(rstN), .matchIn(matchIn), .strb(strb),
    .wrData(wrData), .flagQ(flagQ), .enQ(enQ), .offIdx(offIdx),
    .irqOut(irqOut)
  );

  a_r10_emu_read_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (emuMode && rdEn && addr == ADDR_W'(ADR_OFFSET) && !wrEn && matchIn == '0)
      |=> $stable(flagQ));

  a_r5_no_irq_without_enable: assert property (@(posedge clk) disable iff (!rstN)
    (enQ == '0) |-> !irqOut);
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int N = 3;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] matchIn = '0;
  logic emuMode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic wrEn = 1'b0;
  logic [N-1:0] wrData = '0;
  logic rdEn = 1'b0;
  logic [N-1:0] rdData;
  logic irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(N), .ADDR_W(AW)) u_prio_irq_ctrl (
    .clk(clk), .rstN(rstN), .matchIn(matchIn), .emuMode(emuMode),
    .addr(addr), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .irqOut(irqOut)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doWrite(int a, logic [N-1:0] d, logic [N-1:0] m = '0);
    @(negedge clk);
    addr = AW'(a); wrData = d; wrEn = 1'b1; matchIn = m;
    @(negedge clk);
    wrEn = 1'b0; matchIn = '0;
  endtask

  task automatic doRead(int a, output int v, input logic [N-1:0] m = '0);
    @(negedge clk);
    addr = AW'(a); rdEn = 1'b1; matchIn = m;
    #1 v = int'(rdData);
    @(negedge clk);
    rdEn = 1'b0; matchIn = '0;
  endtask

  task automatic pulse(logic [N-1:0] m);
    @(negedge clk);
    matchIn = m;
    @(negedge clk);
    matchIn = '0;
  endtask

  task automatic clearAll();
    doWrite(2, '1);
    doWrite(1, '1);
  endtask

  task automatic testReset();
    int v;
    check("R1 irq", int'(irqOut), 0);
    doRead(0, v); check("R1 enables", v, 0);
    doRead(2, v); check("R1 flags", v, 0);
    doRead(3, v); check("R1 offset", v, 0);
  endtask

  task automatic testSticky();
    int v;
    pulse(3'b010);
    repeat (3) @(negedge clk);
    doRead(2, v); check("R2 sticky flag", v, 2);
    pulse(3'b100);
    doRead(2, v); check("R2 second flag", v, 6);
    clearAll();
  endtask

  task automatic testEnables();
    int v;
    doWrite(0, 3'b101);
    doRead(0, v); check("R3 set", v, 5);
    doRead(1, v); check("R3 readback at clear addr", v, 5);
    doWrite(0, 3'b000);
    doRead(0, v); check("R3 zero write", v, 5);
    doWrite(1, 3'b001);
    doRead(0, v); check("R4 clear", v, 4);
    doWrite(1, 3'b000);
    doRead(0, v); check("R4 zero write", v, 4);
    clearAll();
  endtask

  task automatic testIrq();
    doWrite(0, 3'b100);
    pulse(3'b010);
    #1 check("R5 flag not enabled", int'(irqOut), 0);
    pulse(3'b100);
    #1 check("R5 asserted", int'(irqOut), 1);
    doWrite(2, 3'b100);
    #1 check("R5 deasserted", int'(irqOut), 0);
    clearAll();
  endtask

  task automatic testW1c();
    int v;
    pulse(3'b111);
    doWrite(2, 3'b010);
    doRead(2, v); check("R6 one bit cleared", v, 5);
    doWrite(2, 3'b000);
    doRead(2, v); check("R6 zero write", v, 5);
    clearAll();
  endtask

  task automatic testOffset();
    int v;
    pulse(3'b101);
    doRead(3, v); check("R7 top source", v, 1);
    doRead(2, v); check("R8 only top cleared", v, 4);
    doRead(3, v); check("R7 next source", v, 3);
    doRead(2, v); check("R8 flags empty", v, 0);
    doRead(3, v); check("R7 none pending", v, 0);
    clearAll();
  endtask

  task automatic testOffWrite();
    int v;
    pulse(3'b010);
    doWrite(3, 3'b111);
    doRead(2, v); check("R9 flags kept", v, 2);
    doRead(0, v); check("R9 enables kept", v, 0);
    doRead(3, v); check("R9 offset intact", v, 2);
    clearAll();
  endtask

  task automatic testEmu();
    int v;
    pulse(3'b011);
    emuMode = 1'b1;
    doRead(3, v); check("R10 emu read", v, 1);
    doRead(3, v); check("R10 emu repeat", v, 1);
    doRead(2, v); check("R10 flags kept", v, 3);
    emuMode = 1'b0;
    doRead(3, v); check("R10 normal after emu", v, 1);
    doRead(2, v); check("R10 ack after emu", v, 2);
    clearAll();
  endtask

  task automatic testSetWins();
    int v;
    pulse(3'b001);
    doWrite(2, 3'b001, 3'b001);
    doRead(2, v); check("R11 write vs match", v, 1);
    doRead(3, v, 3'b001); check("R11 offset value", v, 1);
    doRead(2, v); check("R11 ack vs match", v, 1);
    clearAll();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSticky();
    testEnables();
    testIrq();
    testW1c();
    testOffset();
    testOffWrite();
    testEmu();
    testSetWins();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule